// File: doc/BRIEF.md
# DAC Volume Word Serializer

This block carries a left and a right volume setting to an external digital-to-analog converter over a three-wire write-only link made of a bit clock, a data line and a latch strobe. On a start request it builds two 16-bit control words, one tagged for the left channel and one for the right. It shifts them out most significant bit first and follows each word with its own latch pulse.

A format select chooses how a volume value sits inside the word. The wide format carries a 14-bit volume in the top bits and puts the channel tag in bit 1. The narrow format carries a 10-bit volume in the low bits and puts the channel tag in bit 10. A divider input sets how long every clock phase and every latch pulse lasts. The volumes, the format select and the divider are all captured when a transfer is accepted.

Top module: `dac_vol_serializer`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `busy`, `sclk`, `sdata` and `slatch` are all low.
- R2: Each word is 16 bits and leaves on `sdata` most significant bit first, one bit per rising edge of `sclk`, with exactly 16 rising edges before each latch pulse.
- R3: `sdata` changes only while `sclk` is low and holds its value for the whole high phase of `sclk`.
- R4: After the 16th bit, `sclk` and `sdata` are low while `slatch` is high for one pulse. The rising edge of `slatch` marks the word as complete.
- R5: With `fmt_wide` = 1 the word is the 14-bit volume shifted left by two. Bit 1 is the channel tag (0 left, 1 right) and bit 0 is 0.
- R6: With `fmt_wide` = 0 the word carries volume bits 9:0 in word bits 9:0 and the channel tag (0 left, 1 right) in bit 10. Bits 15:11 are 0.
- R7: Every transfer sends the left word first and then the right word.
- R8: Every high phase of `sclk` and every `slatch` pulse lasts `half_period`+1 clock cycles, as captured at the start.
- R9: `busy` rises on the edge that accepts `start` and stays high for exactly 66×(`half_period`+1) cycles, falling as the second latch pulse ends.
- R10: A `start` pulse that arrives while `busy` is high is ignored: it produces no extra words and does not lengthen the transfer.
- R11: Changes on `vol_left`, `vol_right`, `fmt_wide` or `half_period` during a transfer do not affect the words or timing of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send both volume words |
| fmt_wide | input | 1 | 1 selects the 14-bit word format, 0 selects the 10-bit format |
| vol_left | input | 14 | Left channel volume |
| vol_right | input | 14 | Right channel volume |
| half_period | input | 8 | Phase length minus one, in clock cycles |
| busy | output | 1 | High while a transfer is in progress |
| sclk | output | 1 | Serial bit clock to the converter |
| sdata | output | 1 | Serial data to the converter |
| slatch | output | 1 | Word commit strobe to the converter |

## Verification
The bench sends values whose top and bottom bits differ in both formats. A design that shifts LSB first, puts the tag at the wrong bit, or forgets the 10-bit mask then decodes to a different word. It sends `half_period` of 0, so every phase is a single cycle and an off-by-one in the timer shows up as a wrong phase width or a wrong busy length. In one transfer it pulses `start` and rewrites every input in the middle. A design that restarts, re-samples its inputs or sends an extra word then gives a wrong word, a longer `busy`, or leftover expected words.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

    // Serializer phase; the output pins are decoded from it
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LATCH = 2'd3
    } ser_state_e;

    localparam logic CH_LEFT  = 1'b0;
    localparam logic CH_RIGHT = 1'b1;

endpackage

// File: rtl/dvs_word_fmt.sv
// Builds one channel-tagged control word in either format.
module dvs_word_fmt #(
    parameter int WORD_W      = 16,
    parameter int WIDE_BITS   = 14,
    parameter int NARROW_BITS = 10
) (
    input  logic                 fmt_wide,
    input  logic                 chan_tag,
    input  logic [WIDE_BITS-1:0] vol,
    output logic [WORD_W-1:0]    word
);
    localparam int WIDE_TAG_POS   = WORD_W - WIDE_BITS - 1;
    localparam int NARROW_TAG_POS = NARROW_BITS;

    logic [WORD_W-1:0] word_wide;
    logic [WORD_W-1:0] word_narrow;

    always_comb begin
        word_wide                              = '0;
        word_wide[WORD_W-1 -: WIDE_BITS]       = vol;
        word_wide[WIDE_TAG_POS]                = chan_tag;

        word_narrow                            = '0;
        word_narrow[NARROW_BITS-1:0]           = vol[NARROW_BITS-1:0];
        word_narrow[NARROW_TAG_POS]            = chan_tag;

        word = fmt_wide ? word_wide : word_narrow;
    end

endmodule

// File: rtl/dvs_phase_timer.sv
// Down-counter that ticks on the last cycle of each phase.
module dvs_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == '0) begin
            cnt_d = reload;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/dac_vol_serializer.sv
module dac_vol_serializer
    import dvs_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int WIDE_BITS   = 14,
    parameter int NARROW_BITS = 10,
    parameter int DIV_W       = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 fmt_wide,
    input  logic [WIDE_BITS-1:0] vol_left,
    input  logic [WIDE_BITS-1:0] vol_right,
    input  logic [DIV_W-1:0]     half_period,
    output logic                 busy,
    output logic                 sclk,
    output logic                 sdata,
    output logic                 slatch
);
    localparam int NCH   = 2;
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        ser_state_e          st;
        logic                chan;
        logic [IDX_W-1:0]    bit_idx;
        logic [WORD_W-1:0]   shreg;
        logic [WORD_W-1:0]   word_right;
        logic [DIV_W-1:0]    div;
    } regs_t;

    regs_t r_d, r_q;

    // Per-channel word formatters
    logic [NCH-1:0][WIDE_BITS-1:0] vol_pair;
    logic [NCH-1:0][WORD_W-1:0]    word_fmt;

    assign vol_pair[0] = vol_left;
    assign vol_pair[1] = vol_right;

    for (genvar g = 0; g < NCH; g++) begin : g_fmt
        dvs_word_fmt #(
            .WORD_W      (WORD_W),
            .WIDE_BITS   (WIDE_BITS),
            .NARROW_BITS (NARROW_BITS)
        ) u_fmt (
            .fmt_wide (fmt_wide),
            .chan_tag (1'(g)),
            .vol      (vol_pair[g]),
            .word     (word_fmt[g])
        );
    end

    // Phase timer: follows the divider input while idle, the captured value after
    logic             idle;
    logic             tick;
    logic [DIV_W-1:0] timer_reload;
    logic [DIV_W-1:0] div_q;

    assign idle         = (r_q.st == ST_IDLE);
    assign timer_reload = idle ? half_period : r_q.div;
    assign div_q        = r_q.div;

    dvs_phase_timer #(
        .DIV_W (DIV_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!idle),
        .reload (timer_reload),
        .tick   (tick)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st         = ST_LOW;
                    r_d.chan       = CH_LEFT;
                    r_d.bit_idx    = LAST_IDX;
                    r_d.shreg      = word_fmt[0];
                    r_d.word_right = word_fmt[1];
                    r_d.div        = half_period;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.st = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (r_q.bit_idx == '0) begin
                        r_d.st = ST_LATCH;
                    end else begin
                        r_d.st      = ST_LOW;
                        r_d.bit_idx = r_q.bit_idx - 1'b1;
                        r_d.shreg   = {r_q.shreg[WORD_W-2:0], 1'b0};
                    end
                end
            end
            ST_LATCH: begin
                if (tick) begin
                    if (r_q.chan == CH_LEFT) begin
                        r_d.st      = ST_LOW;
                        r_d.chan    = CH_RIGHT;
                        r_d.bit_idx = LAST_IDX;
                        r_d.shreg   = r_q.word_right;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, chan: 1'b0, bit_idx: '0, shreg: '0,
                     word_right: '0, div: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = !idle;
    assign sclk   = (r_q.st == ST_HIGH);
    assign sdata  = ((r_q.st == ST_LOW) || (r_q.st == ST_HIGH)) && r_q.shreg[WORD_W-1];
    assign slatch = (r_q.st == ST_LATCH);

endmodule

// File: rtl/dvs_checker.sv
module dvs_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             sclk,
    input logic             sdata,
    input logic             slatch,
    input logic [DIV_W-1:0] div_q
);
    // Length of the current high run of sclk or slatch
    logic [DIV_W:0] hi_run;
    logic [DIV_W:0] lat_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= '0;
            lat_run <= '0;
        end else begin
            hi_run  <= sclk   ? hi_run + 1'b1  : '0;
            lat_run <= slatch ? lat_run + 1'b1 : '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata && !slatch));

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    assert_latch_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> (!sclk && !sdata));

    assert_clk_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run == {1'b0, div_q} + 1'b1));

    assert_latch_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slatch) |-> (lat_run == {1'b0, div_q} + 1'b1));

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !slatch) |=> busy);

endmodule

bind dac_vol_serializer dvs_checker #(
    .DIV_W (DIV_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .sclk   (sclk),
    .sdata  (sdata),
    .slatch (slatch),
    .div_q  (div_q)
);

// File: tb/dac_vol_serializer_test.sv
module dac_vol_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_wide = 1'b0;
    logic [13:0] vol_left = '0;
    logic [13:0] vol_right = '0;
    logic [7:0]  half_period = '0;
    logic        busy, sclk, sdata, slatch;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;
    int cur_div = 0;

    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_vol_serializer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_wide(fmt_wide),
        .vol_left(vol_left), .vol_right(vol_right), .half_period(half_period),
        .busy(busy), .sclk(sclk), .sdata(sdata), .slatch(slatch)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected word, computed from the R5/R6 formats
    function automatic logic [15:0] model_word(input bit wide, input logic [13:0] v, input bit ch);
        if (wide) return {v, ch, 1'b0};
        return {5'b0, ch, v[9:0]};
    endfunction

    // Monitor: decodes the pins and scores completed words
    logic [15:0] rx_word = '0;
    int rx_bits = 0, hi_run = 0, lat_run = 0;
    logic prev_sclk = 0, prev_lat = 0, prev_sdata = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                rx_word = {rx_word[14:0], sdata};
                rx_bits++;
            end
            if (sclk && prev_sclk && sdata !== prev_sdata)
                check(0, "R3 data moved in high phase", sdata, prev_sdata);
            if (!sclk && prev_sclk)
                check(hi_run == cur_div + 1, "R8 clock high width", hi_run, cur_div + 1);
            if (!slatch && prev_lat)
                check(lat_run == cur_div + 1, "R8 latch width", lat_run, cur_div + 1);
            if (slatch && !prev_lat) begin
                check(rx_bits == 16, "R2 bits per word", rx_bits, 16);
                check(!sclk && !sdata, "R4 pins low at latch", {sclk, sdata}, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R10 unexpected extra word", rx_word, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rx_word == e, "R2/R5/R6/R7 word value", rx_word, e);
                end
                rx_bits = 0;
            end
            hi_run  = sclk   ? hi_run + 1  : 0;
            lat_run = slatch ? lat_run + 1 : 0;
            prev_sclk  = sclk;
            prev_lat   = slatch;
            prev_sdata = sdata;
        end
    end

    // Driver: starts a transfer, pushes expectations, times busy
    task automatic send(input bit wide, input logic [13:0] vl, input logic [13:0] vr,
                        input int div, input bit poke);
        int busy_cycles;
        @(negedge clk);
        fmt_wide    = wide;
        vol_left    = vl;
        vol_right   = vr;
        half_period = 8'(div);
        cur_div     = div;
        exp_q.push_back(model_word(wide, vl, 1'b0));
        exp_q.push_back(model_word(wide, vr, 1'b1));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cycles = busy ? 1 : 0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        while (busy && busy_cycles < 20000) begin
            @(negedge clk);
            if (poke && busy_cycles == 7 * (div + 1)) begin
                // R10/R11: a start and new inputs in mid-transfer
                start       = 1'b1;
                fmt_wide    = ~wide;
                vol_left    = ~vl;
                vol_right   = ~vr;
                half_period = 8'(div + 3);
            end else begin
                start = 1'b0;
            end
            if (busy) busy_cycles++;
        end
        start = 1'b0;
        check(busy_cycles == 66 * (div + 1), "R9 busy length", busy_cycles, 66 * (div + 1));
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7/R10 words outstanding", exp_q.size(), 0);
        exp_q.delete();
        check(!busy && !sclk && !sdata && !slatch, "R1 idle pins",
              {busy, sclk, sdata, slatch}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!busy && !sclk && !sdata && !slatch, "R1 reset state",
              {busy, sclk, sdata, slatch}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !sclk && !sdata && !slatch, "R1 after reset",
              {busy, sclk, sdata, slatch}, 0);

        send(1'b1, 14'h2A5C, 14'h1003, 2, 0);   // R5 wide format
        send(1'b0, 14'h3E81, 14'h017E, 1, 0);   // R6 narrow format, upper bits dropped
        send(1'b1, 14'h3FFF, 14'h0000, 0, 0);   // R8 one-cycle phases
        send(1'b0, 14'h0000, 14'h03FF, 0, 0);   // R6 tag vs value bits
        send(1'b1, 14'h0001, 14'h2000, 3, 1);   // R10 R11 mid-transfer poke
        send(1'b0, 14'h1555, 14'h2AAA, 2, 1);   // R10 R11 in narrow format

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule